// File: doc/BRIEF.md
# CAN Frame Receiver with Acknowledge

This block turns the sampled level of a CAN bus into decoded frames. A bit-timing stage upstream (not part of this block) presents one bus sample per `bit_en` pulse on `rx_bit`, where 0 is dominant and 1 is recessive. The receiver finds the start of a frame and strips the stuff bits. It reads the header in either the 11-bit or the 29-bit layout, chosen by the identifier-extension bit. It then gathers the length code and payload, and checks the 15-bit CRC. When the checksum matches, it pulls its `tx_bit` output dominant for the acknowledge slot.

The controller is built around the state machine `canfr_ctl`. Its states are ST_IDLE, ST_BASE_ID, ST_BIT12 (remote flag in a standard header, substitute bit in an extended one), ST_IDE, ST_EXT_ID, ST_RTR_X, ST_R1, ST_R0, ST_DLC, ST_DATA, ST_CRC, ST_CRC_DEL, ST_ACK, ST_ACK_DEL and ST_EOF. Its transitions are:
- IDLE→BASE_ID on a dominant sample.
- BASE_ID→BIT12 after 11 bits, then BIT12→IDE.
- IDE→R0 when IDE is dominant; IDE→EXT_ID when it is recessive.
- EXT_ID→RTR_X after 18 bits, then RTR_X→R1→R0.
- R0→DLC.
- DLC→CRC for a remote frame or a zero length; DLC→DATA otherwise.
- DATA→CRC after the last payload bit, then CRC→CRC_DEL after 15 bits.
- CRC_DEL→ACK→ACK_DEL→EOF.
- EOF→IDLE after seven bits.
- Any state→IDLE on a stuff error, and the delimiter and end-of-frame states→IDLE on a form error.

A stuff bit is consumed without advancing any state.

Top module: `canfr_receiver`

## Requirements
- R1: While idle, recessive samples are ignored and raise no strobe. The first dominant sample is taken as start of frame. After reset `tx_bit` is 1 and all strobes are 0.
- R2: From start of frame through the CRC-delimiter position, a sample that follows five equal sampled bits is a stuff bit. It is removed from the header, data and CRC streams. This holds when it directly follows the last CRC bit: it is then not mistaken for the CRC delimiter.
- R3: A stuff bit equal to the five bits before it pulses `err_stuff` for one clock, and the receiver returns to idle.
- R4: A dominant IDE bit selects the standard layout: 11 identifier bits, then the remote bit, IDE, r0 and a 4-bit length code. `frm_id[10:0]` holds the identifier with bits 28:11 zero, and `frm_ext` is 0.
- R5: A recessive IDE bit selects the extended layout. The order is 11 base bits, a substitute bit, IDE, 18 further bits, then the remote bit, r1, r0 and the length code. `frm_id` holds the base part in bits 28:18 and the rest in 17:0, and `frm_ext` is 1.
- R6: A recessive remote bit sets `frm_rtr`. No payload is read, and `frm_data` is zero.
- R7: The payload has `frm_dlc` bytes, and codes 9 to 15 are read as 8 bytes while `frm_dlc` shows the raw code. Byte k lands at `frm_data[8k+7:8k]`, and its first received bit is the byte's MSB. Unreceived bytes read zero.
- R8: The CRC uses polynomial 0x4599 with a zero start value, over the destuffed bits from start of frame through the payload. On a mismatch `err_crc` pulses for one clock at the CRC-delimiter sample, and no `frm_valid` follows for that frame.
- R9: When the CRC matches, `tx_bit` is 0 from the CRC-delimiter sample until the acknowledge-slot sample. At all other times it is 1.
- R10: A dominant sample in the CRC delimiter, the acknowledge delimiter or any end-of-frame bit pulses `err_form` and returns the receiver to idle.
- R11: `frm_valid` pulses for one clock after the seventh end-of-frame sample of a frame whose CRC matched. The frame fields update only then and hold otherwise. No two strobes are ever high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bit_en | input | 1 | One-clock pulse per bus bit sample |
| rx_bit | input | 1 | Sampled bus level, 0 dominant |
| tx_bit | output | 1 | Acknowledge drive, 0 dominant |
| frm_valid | output | 1 | Good frame strobe |
| frm_id | output | 29 | Received identifier |
| frm_ext | output | 1 | Extended layout flag |
| frm_rtr | output | 1 | Remote frame flag |
| frm_dlc | output | 4 | Raw length code |
| frm_data | output | 64 | Payload bytes |
| err_stuff | output | 1 | Stuff error strobe |
| err_crc | output | 1 | CRC error strobe |
| err_form | output | 1 | Form error strobe |

## Verification
Stuff-bit removal and the CRC-delimiter decision can fall on the same sample. This happens when the checksum ends in a run of five equal bits, so the stuff bit sits where a delimiter would otherwise be checked. The bench searches payload values until its own encoder places a stuff bit right after the last CRC bit. It then requires that no form error is raised, that the acknowledge is still driven, and that the frame is accepted with the right fields. Every clock is compared against a behavioural frame model that builds the stuffed bit stream and the expected acknowledge and strobe for each sample.

// File: rtl/canfr_pkg.sv
package canfr_pkg;
    localparam int BASE_ID_W = 11;
    localparam int EXT_ID_W  = 18;
    localparam int ID_W      = BASE_ID_W + EXT_ID_W;
    localparam int DLC_W     = 4;
    localparam int MAX_BYTES = 8;
    localparam int DATA_W    = MAX_BYTES * 8;
    localparam int CRC_W     = 15;
    localparam logic [CRC_W-1:0] CRC_POLY = 15'h4599;
    localparam int STUFF_RUN = 5;
    localparam int EOF_LEN   = 7;
    localparam int CNT_W     = $clog2(DATA_W);

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_BASE_ID,
        ST_BIT12,
        ST_IDE,
        ST_EXT_ID,
        ST_RTR_X,
        ST_R1,
        ST_R0,
        ST_DLC,
        ST_DATA,
        ST_CRC,
        ST_CRC_DEL,
        ST_ACK,
        ST_ACK_DEL,
        ST_EOF
    } rx_state_t;
endpackage

// File: rtl/canfr_destuff.sv
module canfr_destuff #(
    parameter int RUN = 5
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic restart,
    input  logic active,
    input  logic din,
    output logic drop,
    output logic serr
);
    localparam int RW = $clog2(RUN + 1);

    logic [RW-1:0] run_q;
    logic          last_q;

    // the sample after a full run is a stuff bit
    assign drop = active && (run_q == RW'(RUN));
    assign serr = drop && (din == last_q);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            run_q  <= '0;
            last_q <= 1'b1;
        end else if (tick) begin
            if (restart) begin
                run_q  <= RW'(1);
                last_q <= din;
            end else if (active) begin
                if (drop || (din != last_q)) begin
                    run_q  <= RW'(1);
                    last_q <= din;
                end else begin
                    run_q <= run_q + RW'(1);
                end
            end
        end
    end

    AST_RUN_CAP: assert property (@(posedge clk) disable iff (!rst_n) int'(run_q) <= RUN); // R2
endmodule

// File: rtl/canfr_crc.sv
module canfr_crc #(
    parameter int             W    = 15,
    parameter logic [W-1:0]   POLY = 15'h4599
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         tick,
    input  logic         clear,
    input  logic         shift,
    input  logic         din,
    output logic [W-1:0] rem
);
    logic fb;
    assign fb = din ^ rem[W-1];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rem <= '0;
        end else if (tick) begin
            if (clear) begin
                rem <= '0;
            end else if (shift) begin
                rem <= {rem[W-2:0], 1'b0} ^ (fb ? POLY : '0);
            end
        end
    end
endmodule

// File: rtl/canfr_ctl.sv
module canfr_ctl
    import canfr_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              din,
    input  logic              drop,
    input  logic              serr,
    input  logic              crc_zero,
    output logic              restart,
    output logic              stuff_on,
    output logic              crc_shift,
    output logic              tx_bit,
    output logic              frm_valid,
    output logic [ID_W-1:0]   frm_id,
    output logic              frm_ext,
    output logic              frm_rtr,
    output logic [DLC_W-1:0]  frm_dlc,
    output logic [DATA_W-1:0] frm_data,
    output logic              err_stuff,
    output logic              err_crc,
    output logic              err_form
);
    rx_state_t          state_q, state_d;
    logic [CNT_W-1:0]   cnt_q;
    logic [ID_W-1:0]    id_sr;
    logic               rtr_sr, ext_sr, crc_ok_q;
    logic [DLC_W-1:0]   dlc_sr, dlc_next, eff_len;
    logic [DATA_W-1:0]  data_sr;
    logic [CNT_W:0]     data_len;
    logic               take;

    assign take     = tick && !drop;
    assign dlc_next = {dlc_sr[DLC_W-2:0], din};
    assign eff_len  = (dlc_sr > DLC_W'(MAX_BYTES)) ? DLC_W'(MAX_BYTES) : dlc_sr;
    assign data_len = (CNT_W+1)'(eff_len) << 3;

    assign restart   = (state_q == ST_IDLE) && !din;
    assign stuff_on  = (state_q inside {ST_BASE_ID, ST_BIT12, ST_IDE, ST_EXT_ID, ST_RTR_X,
                                        ST_R1, ST_R0, ST_DLC, ST_DATA, ST_CRC, ST_CRC_DEL});
    assign crc_shift = !drop && (state_q inside {ST_BASE_ID, ST_BIT12, ST_IDE, ST_EXT_ID, ST_RTR_X,
                                                 ST_R1, ST_R0, ST_DLC, ST_DATA, ST_CRC});
    assign tx_bit    = !((state_q == ST_ACK) && crc_ok_q);

    // next state
    always_comb begin
        state_d = state_q;
        if (tick && serr) begin
            state_d = ST_IDLE;
        end else if (take) begin
            unique case (state_q)
                ST_IDLE:    if (!din) state_d = ST_BASE_ID;
                ST_BASE_ID: if (cnt_q == CNT_W'(BASE_ID_W-1)) state_d = ST_BIT12;
                ST_BIT12:   state_d = ST_IDE;
                ST_IDE:     state_d = din ? ST_EXT_ID : ST_R0;
                ST_EXT_ID:  if (cnt_q == CNT_W'(EXT_ID_W-1)) state_d = ST_RTR_X;
                ST_RTR_X:   state_d = ST_R1;
                ST_R1:      state_d = ST_R0;
                ST_R0:      state_d = ST_DLC;
                ST_DLC: begin
                    if (cnt_q == CNT_W'(DLC_W-1))
                        state_d = (rtr_sr || (dlc_next == '0)) ? ST_CRC : ST_DATA;
                end
                ST_DATA:    if ({1'b0, cnt_q} == data_len - 1'b1) state_d = ST_CRC;
                ST_CRC:     if (cnt_q == CNT_W'(CRC_W-1)) state_d = ST_CRC_DEL;
                ST_CRC_DEL: state_d = din ? ST_ACK : ST_IDLE;
                ST_ACK:     state_d = ST_ACK_DEL;
                ST_ACK_DEL: state_d = din ? ST_EOF : ST_IDLE;
                ST_EOF: begin
                    if (!din || (cnt_q == CNT_W'(EOF_LEN-1))) state_d = ST_IDLE;
                end
                default:    state_d = ST_IDLE;
            endcase
        end
    end

    // state register and bit counter
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
        end else if (tick && (take || serr)) begin
            state_q <= state_d;
            cnt_q   <= (state_d != state_q) ? '0 : cnt_q + 1'b1;
        end
    end

    // field capture and strobes
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            id_sr     <= '0;
            rtr_sr    <= 1'b0;
            ext_sr    <= 1'b0;
            dlc_sr    <= '0;
            data_sr   <= '0;
            crc_ok_q  <= 1'b0;
            frm_valid <= 1'b0;
            frm_id    <= '0;
            frm_ext   <= 1'b0;
            frm_rtr   <= 1'b0;
            frm_dlc   <= '0;
            frm_data  <= '0;
            err_stuff <= 1'b0;
            err_crc   <= 1'b0;
            err_form  <= 1'b0;
        end else begin
            frm_valid <= 1'b0;
            err_stuff <= 1'b0;
            err_crc   <= 1'b0;
            err_form  <= 1'b0;
            if (tick && serr) begin
                err_stuff <= 1'b1;
            end else if (take) begin
                unique case (state_q)
                    ST_IDLE: begin
                        if (!din) begin
                            id_sr    <= '0;
                            rtr_sr   <= 1'b0;
                            ext_sr   <= 1'b0;
                            dlc_sr   <= '0;
                            data_sr  <= '0;
                            crc_ok_q <= 1'b0;
                        end
                    end
                    ST_BASE_ID, ST_EXT_ID: id_sr <= {id_sr[ID_W-2:0], din};
                    ST_BIT12, ST_RTR_X:    rtr_sr <= din;
                    ST_IDE:                ext_sr <= din;
                    ST_DLC:                dlc_sr <= dlc_next;
                    ST_DATA:               data_sr[{cnt_q[CNT_W-1:3], ~cnt_q[2:0]}] <= din;
                    ST_CRC_DEL: begin
                        if (!din) begin
                            err_form <= 1'b1;
                        end else begin
                            crc_ok_q <= crc_zero;
                            err_crc  <= !crc_zero;
                        end
                    end
                    ST_ACK_DEL: err_form <= !din;
                    ST_EOF: begin
                        if (!din) begin
                            err_form <= 1'b1;
                        end else if ((cnt_q == CNT_W'(EOF_LEN-1)) && crc_ok_q) begin
                            frm_valid <= 1'b1;
                            frm_id    <= id_sr;
                            frm_ext   <= ext_sr;
                            frm_rtr   <= rtr_sr;
                            frm_dlc   <= dlc_sr;
                            frm_data  <= data_sr;
                        end
                    end
                    default: ;
                endcase
            end
        end
    end

    AST_ONE_EVENT: assert property (@(posedge clk) disable iff (!rst_n) $onehot0({frm_valid, err_stuff, err_crc, err_form})); // R11
    AST_EVENT_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n) (frm_valid || err_stuff || err_crc || err_form) |-> $past(tick)); // R11
    AST_ERR_TO_IDLE: assert property (@(posedge clk) disable iff (!rst_n) (err_stuff || err_form) |-> (state_q == ST_IDLE)); // R10
    AST_NO_ACK_BAD_CRC: assert property (@(posedge clk) disable iff (!rst_n) err_crc |=> tx_bit); // R9
    AST_TX_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n) $fell(tx_bit) |-> $past(tick)); // R9
endmodule

// File: rtl/canfr_receiver.sv
module canfr_receiver
    import canfr_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bit_en,
    input  logic              rx_bit,
    output logic              tx_bit,
    output logic              frm_valid,
    output logic [ID_W-1:0]   frm_id,
    output logic              frm_ext,
    output logic              frm_rtr,
    output logic [DLC_W-1:0]  frm_dlc,
    output logic [DATA_W-1:0] frm_data,
    output logic              err_stuff,
    output logic              err_crc,
    output logic              err_form
);
    logic             drop, serr, restart, stuff_on, crc_shift;
    logic [CRC_W-1:0] crc_rem;

    canfr_destuff #(.RUN(STUFF_RUN)) u_destuff (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick    (bit_en),
        .restart (restart),
        .active  (stuff_on),
        .din     (rx_bit),
        .drop    (drop),
        .serr    (serr)
    );

    canfr_crc #(.W(CRC_W), .POLY(CRC_POLY)) u_crc (
        .clk   (clk),
        .rst_n (rst_n),
        .tick  (bit_en),
        .clear (restart),
        .shift (crc_shift),
        .din   (rx_bit),
        .rem   (crc_rem)
    );

    canfr_ctl u_ctl (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick      (bit_en),
        .din       (rx_bit),
        .drop      (drop),
        .serr      (serr),
        .crc_zero  (crc_rem == '0),
        .restart   (restart),
        .stuff_on  (stuff_on),
        .crc_shift (crc_shift),
        .tx_bit    (tx_bit),
        .frm_valid (frm_valid),
        .frm_id    (frm_id),
        .frm_ext   (frm_ext),
        .frm_rtr   (frm_rtr),
        .frm_dlc   (frm_dlc),
        .frm_data  (frm_data),
        .err_stuff (err_stuff),
        .err_crc   (err_crc),
        .err_form  (err_form)
    );
endmodule

// File: tb/sim_canfr_receiver.sv
`timescale 1ns/1ps
module sim_canfr_receiver;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bit_en = 1'b0;
    logic        rx_bit = 1'b1;
    logic        tx_bit, frm_valid, frm_ext, frm_rtr, err_stuff, err_crc, err_form;
    logic [28:0] frm_id;
    logic [3:0]  frm_dlc;
    logic [63:0] frm_data;

    always #2.5 clk = ~clk;

    canfr_receiver u0 (
        .clk(clk), .rst_n(rst_n), .bit_en(bit_en), .rx_bit(rx_bit), .tx_bit(tx_bit),
        .frm_valid(frm_valid), .frm_id(frm_id), .frm_ext(frm_ext), .frm_rtr(frm_rtr),
        .frm_dlc(frm_dlc), .frm_data(frm_data), .err_stuff(err_stuff),
        .err_crc(err_crc), .err_form(err_form)
    );

    int n_vec = 0;
    int n_bad = 0;
    bit done  = 0;

    // model of one frame on the bus
    bit raw[$];
    bit fb[$];
    int ftx[$];
    int fev[$];          // 0 none, 1 valid, 2 stuff, 3 crc, 4 form
    int i_crcdel, i_ack, i_ackdel, i_eof0, i_stuff1;
    bit stuff_tail, f_good;
    logic [28:0] p_id, h_id;
    logic        p_ext, p_rtr, h_ext, h_rtr;
    logic [3:0]  p_dlc, h_dlc;
    logic [63:0] p_data, h_data;

    task automatic chk(input logic [63:0] act, input logic [63:0] exp, input string tag, input string what);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    function automatic logic [14:0] crc_of(input bit b[$]);
        logic [14:0] r;
        r = '0;
        foreach (b[i]) begin
            logic f;
            f = b[i] ^ r[14];
            r = {r[13:0], 1'b0};
            if (f) r = r ^ 15'h4599;
        end
        return r;
    endfunction

    function automatic logic [3:0] ev_vec(input int e);
        case (e)
            1: return 4'b1000;
            2: return 4'b0100;
            3: return 4'b0010;
            4: return 4'b0001;
            default: return 4'b0000;
        endcase
    endfunction

    task automatic build(input bit ext, input bit rtr, input logic [28:0] id,
                         input logic [3:0] dlc, input logic [63:0] data, input int flip);
        int nb;
        int run;
        bit last;
        logic [14:0] c;
        raw.delete(); fb.delete(); ftx.delete(); fev.delete();
        raw.push_back(1'b0);
        for (int k = 28; k >= 18; k--) raw.push_back(ext ? id[k] : id[k-18]);
        if (ext) begin
            raw.push_back(1'b1); raw.push_back(1'b1);
            for (int k = 17; k >= 0; k--) raw.push_back(id[k]);
            raw.push_back(rtr); raw.push_back(1'b0); raw.push_back(1'b0);
        end else begin
            raw.push_back(rtr); raw.push_back(1'b0); raw.push_back(1'b0);
        end
        for (int k = 3; k >= 0; k--) raw.push_back(dlc[k]);
        nb = rtr ? 0 : ((dlc > 8) ? 8 : int'(dlc));
        p_data = '0;
        for (int by = 0; by < nb; by++) begin
            for (int k = 7; k >= 0; k--) raw.push_back(data[8*by+k]);
            p_data[8*by +: 8] = data[8*by +: 8];
        end
        c = crc_of(raw);
        if (flip >= 0) raw[flip] = !raw[flip];
        for (int k = 14; k >= 0; k--) raw.push_back(c[k]);
        run = 0; last = 1'b1; i_stuff1 = -1; stuff_tail = 0;
        foreach (raw[j]) begin
            fb.push_back(raw[j]);
            if (j == 0 || raw[j] != last) begin run = 1; last = raw[j]; end
            else run++;
            if (run == 5) begin
                fb.push_back(!last);
                if (i_stuff1 < 0) i_stuff1 = fb.size() - 1;
                if (j == raw.size() - 1) stuff_tail = 1;
                last = !last;
                run = 1;
            end
        end
        f_good = (flip < 0);
        foreach (fb[j]) begin ftx.push_back(1); fev.push_back(0); end
        i_crcdel = fb.size(); fb.push_back(1'b1); ftx.push_back(1); fev.push_back(f_good ? 0 : 3);
        i_ack = fb.size();    fb.push_back(!f_good); ftx.push_back(f_good ? 0 : 1); fev.push_back(0);
        i_ackdel = fb.size(); fb.push_back(1'b1); ftx.push_back(1); fev.push_back(0);
        i_eof0 = fb.size();
        for (int k = 0; k < 7; k++) begin fb.push_back(1'b1); ftx.push_back(1); fev.push_back(0); end
        if (f_good) fev[fb.size()-1] = 1;
        p_id  = ext ? id : {18'b0, id[10:0]};
        p_ext = ext; p_rtr = rtr; p_dlc = dlc;
    endtask

    task automatic cut(input int k, input int code);
        fev[k] = code;
        f_good = 0;
        while (fb.size() > k + 1) begin
            void'(fb.pop_back()); void'(ftx.pop_back()); void'(fev.pop_back());
        end
    endtask

    task automatic idle_bits(input int n);
        for (int j = 0; j < n; j++) begin
            @(negedge clk); rx_bit = 1'b1; bit_en = 1'b1;
            chk(tx_bit, 1, "R1", "idle tx");
            @(negedge clk); bit_en = 1'b0;
            chk({frm_valid, err_stuff, err_crc, err_form}, 0, "R1", "idle strobes");
            @(negedge clk);
        end
    endtask

    task automatic run_frame(input string tag);
        for (int j = 0; j < fb.size(); j++) begin
            @(negedge clk); rx_bit = fb[j]; bit_en = 1'b1;
            chk(tx_bit, ftx[j], "R9", "ack drive");
            @(negedge clk); bit_en = 1'b0;
            chk({frm_valid, err_stuff, err_crc, err_form}, ev_vec(fev[j]), tag, "strobes");
            if (fev[j] == 1) begin
                chk(frm_id, p_id, p_ext ? "R5" : "R4", "id");
                chk(frm_ext, p_ext, p_ext ? "R5" : "R4", "ext flag");
                chk(frm_rtr, p_rtr, "R6", "rtr flag");
                chk(frm_dlc, p_dlc, "R7", "dlc");
                chk(frm_data, p_data, p_rtr ? "R6" : "R7", "data");
            end
            @(negedge clk);
            chk({frm_valid, err_stuff, err_crc, err_form}, 0, "R11", "strobe width");
        end
        if (f_good) begin
            h_id = p_id; h_ext = p_ext; h_rtr = p_rtr; h_dlc = p_dlc; h_data = p_data;
        end else begin
            chk(frm_id, h_id, "R11", "held id");
            chk(frm_data, h_data, "R11", "held data");
            chk(frm_dlc, h_dlc, "R11", "held dlc");
        end
        idle_bits(4);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: actual expired expected finished");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    initial begin
        int found;
        h_id = '0; h_ext = 0; h_rtr = 0; h_dlc = '0; h_data = '0;
        repeat (4) @(negedge clk);
        chk(tx_bit, 1, "R1", "reset tx");
        chk({frm_valid, err_stuff, err_crc, err_form}, 0, "R1", "reset strobes");
        rst_n = 1'b1;
        idle_bits(5);

        build(0, 0, 29'h555, 4'd2, 64'h5AA5, -1);               run_frame("R4");
        build(1, 0, 29'h1ABCDEF1, 4'd8, 64'h0123_4567_89AB_CDEF, -1); run_frame("R5");
        build(0, 1, 29'h2F0, 4'd4, 64'hFFFF_FFFF, -1);          run_frame("R6");
        build(0, 0, 29'h07F, 4'd12, 64'hFEDC_BA98_7654_3210, -1); run_frame("R7");
        build(1, 1, 29'h00F0F0F0, 4'd0, 64'h0, -1);             run_frame("R6");
        build(0, 0, 29'h000, 4'd0, 64'h0, -1);                  run_frame("R2");

        build(0, 0, 29'h321, 4'd3, 64'h00C0FFEE, 20);           run_frame("R8");

        build(0, 0, 29'h000, 4'd0, 64'h0, -1);
        fb[i_stuff1] = !fb[i_stuff1]; cut(i_stuff1, 2);         run_frame("R3");

        build(0, 0, 29'h1A5, 4'd1, 64'h3C, -1);
        fb[i_crcdel] = 1'b0; cut(i_crcdel, 4);                  run_frame("R10");
        build(1, 0, 29'h0ABCDE, 4'd1, 64'h81, -1);
        fb[i_ackdel] = 1'b0; cut(i_ackdel, 4);                  run_frame("R10");
        build(0, 0, 29'h6E1, 4'd2, 64'h1234, -1);
        fb[i_eof0+3] = 1'b0; cut(i_eof0 + 3, 4);                run_frame("R10");

        // stuff bit right behind the last CRC bit (R2)
        found = -1;
        for (int v = 0; v < 256 && found < 0; v++) begin
            build(0, 0, 29'h123, 4'd1, 64'(v), -1);
            if (stuff_tail) found = v;
        end
        chk(found >= 0, 1, "R2", "tail stuff case found");
        if (found >= 0) begin
            build(0, 0, 29'h123, 4'd1, 64'(found), -1);         run_frame("R2");
        end

        build(0, 0, 29'h7FF, 4'd8, 64'hA1B2_C3D4_E5F6_0718, -1); run_frame("R1");

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule